// File: doc/BRIEF.md
# CAS-before-RAS Refresh Detector

This block models the device side of an asynchronous-strobe memory refresh interface. It samples the active-low row strobe, column strobe and write enable on every clock. Each time the row strobe is first seen low, it classifies that edge into one of three outcomes. If the column strobe was high beforehand, the edge is a normal row activation and the external address is latched. If the column strobe was already low, the edge is a refresh cycle. If the column strobe was already low but write enable is low, the edge is a protocol violation.

A refresh uses a row counter inside the block instead of the external address. The row it refreshed is reported on a one-cycle strobe, and the counter then moves to the next row, wrapping at the end of its range. The counter has no reset: its power-up value comes from a seed parameter, and it keeps its value when the block reset is asserted.

A refresh can follow a read while the column strobe stays low. This is a hidden refresh. During it the block raises an output-hold flag, which means the read data must stay on the bus until the column strobe rises.

Top module: `cbr_refresh_detect`

## Requirements
- R1: After reset, ref_stb, act_stb, viol and dout_hold are 0, and act_row and ref_row are 0.
- R2: Suppose the row strobe is sampled low one clock after being sampled high, and the column strobe was sampled high on that earlier clock. Then act_stb is 1 for exactly the following cycle, and act_row holds the addr value sampled on the falling clock.
- R3: Suppose the row strobe is sampled low one clock after being sampled high, the column strobe was sampled low on that earlier clock, and we_n is sampled high. Then ref_stb is 1 for exactly the following cycle, and ref_row shows the counter value before it steps.
- R4: Each performed refresh advances the row counter by one, and the counter wraps from 2^ROW_W-1 to 0.
- R5: The first refresh after power-up reports ROW_SEED. Asserting rst_n low does not change the counter.
- R6: A refresh-type falling edge with we_n sampled low gives a one-cycle viol pulse. No ref_stb follows, and the counter does not step.
- R7: On a refresh or violating edge, addr is ignored: act_row keeps its previous value and act_stb stays 0.
- R8: Suppose the column strobe falls while a row is open from an activation with we_n high (a read), and it stays low through a later refresh. Then dout_hold is 1 from the cycle after that refresh edge until the cycle after the column strobe is sampled high. A refresh not preceded by such a read leaves dout_hold at 0.
- R9: At most one of ref_stb, act_stb and viol is 1 in any cycle. Keeping the row strobe low for several clocks produces only one event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset for everything except the row counter |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | External row address |
| act_stb | output | 1 | One-cycle pulse for a normal row activation |
| act_row | output | ADDR_W | Address latched by the last activation |
| ref_stb | output | 1 | One-cycle pulse for a performed refresh |
| ref_row | output | ROW_W | Row refreshed by the last refresh |
| viol | output | 1 | One-cycle pulse for a refresh edge with write enable low |
| dout_hold | output | 1 | Read data must stay driven (hidden refresh) |

## Verification
The bench sets the seed near the top of the counter range, so the wrap from the maximum row to zero is reached within a handful of refreshes. A design that saturated at the maximum row, or that cleared to zero, would report the wrong row there. A write-enabled refresh edge is placed between two good refreshes: a design that still stepped the counter would skip a row. A design that latched the junk address would change act_row. A reset is pulsed in the middle of a refresh run, and a design that cleared the counter would restart at the seed or at zero. Hidden and plain refreshes run one after the other, which catches a hold flag that rises without a preceding read or drops before the column strobe rises. A long low phase of the row strobe catches a detector that fires more than once.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    // Classification of one row-strobe falling edge
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ACT  = 2'd1,
        EV_REF  = 2'd2,
        EV_BAD  = 2'd3
    } ras_event_e;

    // Previous-sample strobe state
    typedef struct packed {
        logic ras;
        logic cas;
    } strobe_t;

    // Edge classification from previous and present samples
    function automatic ras_event_e classify(input strobe_t prev, input logic ras_now,
                                            input logic we_now);
        ras_event_e ev;
        ev = EV_NONE;
        if (prev.ras && !ras_now) begin
            if (prev.cas)
                ev = EV_ACT;
            else if (we_now)
                ev = EV_REF;
            else
                ev = EV_BAD;
        end
        return ev;
    endfunction

endpackage

// File: rtl/cbr_edge_classify.sv
module cbr_edge_classify
    import cbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output ras_event_e ev,
    output logic       cas_prev_n
);

    strobe_t st_d, st_q;

    always_comb begin
        st_d.ras = ras_n;
        st_d.cas = cas_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ras <= 1'b1;
            st_q.cas <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ev         = classify(st_q, ras_n, we_n);
        cas_prev_n = st_q.cas;
    end

    // An event can only follow a sample with the row strobe high
    AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_NONE) |=> (ev == EV_NONE)); // R9

    AST_REF_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_REF) |-> !$past(cas_n)); // R3

endmodule

// File: rtl/cbr_row_counter.sv
module cbr_row_counter #(
    parameter int ROW_W    = 10,
    parameter int ROW_SEED = 1020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] SEED_V = ROW_W'(ROW_SEED);
    localparam logic [ROW_W-1:0] ONE_V  = ROW_W'(1);

    // No reset: the power-up value is the seed and survives rst_n
    logic [ROW_W-1:0] row_d;
    logic [ROW_W-1:0] row_q = SEED_V;

    always_comb begin
        row_d = row_q;
        if (step)
            row_d = row_q + ONE_V;
    end

    always_ff @(posedge clk) begin
        row_q <= row_d;
    end

    assign row = row_q;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (row_q == $past(row_q) + ONE_V)); // R4

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_q)); // R6

endmodule

// File: rtl/cbr_hold_tracker.sv
module cbr_hold_tracker
    import cbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cas_prev_n,
    input  ras_event_e ev,
    output logic       dout_hold
);

    typedef struct packed {
        logic row_open;
        logic rd_open;
        logic hold;
    } trk_t;

    trk_t t_d, t_q;
    logic cas_fall;

    always_comb begin
        cas_fall = cas_prev_n && !cas_n;
        t_d      = t_q;

        // Row opened by a normal activation, closed when RAS rises
        if (ev == EV_ACT)
            t_d.row_open = 1'b1;
        else if (ras_n)
            t_d.row_open = 1'b0;

        // Read data driven while CAS stays low after a read
        if (cas_n)
            t_d.rd_open = 1'b0;
        else if (t_q.row_open && !ras_n && cas_fall && we_n)
            t_d.rd_open = 1'b1;

        // Hidden refresh: refresh with read data still driven
        if (cas_n)
            t_d.hold = 1'b0;
        else if (ev == EV_REF && t_q.rd_open)
            t_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '0;
        else
            t_q <= t_d;
    end

    assign dout_hold = t_q.hold;

    AST_HOLD_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.hold |-> !$past(cas_n)); // R8

    AST_HOLD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.hold) |-> $past(t_q.rd_open)); // R8

endmodule

// File: rtl/cbr_refresh_detect.sv
module cbr_refresh_detect
    import cbr_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int ADDR_W   = 12,
    parameter int ROW_SEED = 1020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              act_stb,
    output logic [ADDR_W-1:0] act_row,
    output logic              ref_stb,
    output logic [ROW_W-1:0]  ref_row,
    output logic              viol,
    output logic              dout_hold
);

    typedef struct packed {
        logic              act_stb;
        logic [ADDR_W-1:0] act_row;
        logic              ref_stb;
        logic [ROW_W-1:0]  ref_row;
        logic              viol;
    } out_t;

    ras_event_e       ev;
    logic             cas_prev_n;
    logic             do_ref;
    logic [ROW_W-1:0] cur_row;
    out_t             o_d, o_q;

    cbr_edge_classify u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ev         (ev),
        .cas_prev_n (cas_prev_n)
    );

    assign do_ref = rst_n && (ev == EV_REF);

    cbr_row_counter #(
        .ROW_W    (ROW_W),
        .ROW_SEED (ROW_SEED)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (do_ref),
        .row   (cur_row)
    );

    cbr_hold_tracker u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .cas_prev_n (cas_prev_n),
        .ev         (ev),
        .dout_hold  (dout_hold)
    );

    always_comb begin
        o_d         = o_q;
        o_d.act_stb = 1'b0;
        o_d.ref_stb = 1'b0;
        o_d.viol    = 1'b0;
        unique case (ev)
            EV_ACT: begin
                o_d.act_stb = 1'b1;
                o_d.act_row = addr;
            end
            EV_REF: begin
                o_d.ref_stb = 1'b1;
                o_d.ref_row = cur_row;
            end
            EV_BAD:  o_d.viol = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            o_q <= '0;
        else
            o_q <= o_d;
    end

    assign act_stb = o_q.act_stb;
    assign act_row = o_q.act_row;
    assign ref_stb = o_q.ref_stb;
    assign ref_row = o_q.ref_row;
    assign viol    = o_q.viol;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_q.act_stb, o_q.ref_stb, o_q.viol})); // R9

    AST_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_REF || ev == EV_BAD) |=> $stable(o_q.act_row)); // R7

    AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.ref_stb |=> !o_q.ref_stb); // R3

    AST_ACT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.act_stb |=> !o_q.act_stb); // R2

endmodule

// File: tb/sim_cbr_refresh_detect.sv
`timescale 1ns/100ps
module sim_cbr_refresh_detect;

    localparam int ROW_W    = 10;
    localparam int ADDR_W   = 12;
    localparam int ROW_SEED = 1020;
    localparam int ROW_MAX  = (1 << ROW_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n  = 1'b1;
    logic [ADDR_W-1:0] addr  = '0;
    logic              act_stb, ref_stb, viol, dout_hold;
    logic [ADDR_W-1:0] act_row;
    logic [ROW_W-1:0]  ref_row;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_row = ROW_SEED;
    int exp_act = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cbr_refresh_detect #(
        .ROW_W(ROW_W), .ADDR_W(ADDR_W), .ROW_SEED(ROW_SEED)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .act_stb(act_stb), .act_row(act_row), .ref_stb(ref_stb),
        .ref_row(ref_row), .viol(viol), .dout_hold(dout_hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive away from the edge, sample just after the next rising edge
    task automatic step(input logic r, input logic c, input logic w, input int a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; addr = ADDR_W'(a);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 act_stb", act_stb, 0);
        chk("R1 ref_stb", ref_stb, 0);
        chk("R1 viol", viol, 0);
        chk("R1 dout_hold", dout_hold, 0);
        chk("R1 act_row", act_row, 0);
        chk("R1 ref_row", ref_row, 0);
    endtask

    task automatic t_activate(input int a);
        step(1, 1, 1, 0);
        step(0, 1, 1, a);
        exp_act = a;
        chk("R2 act_stb", act_stb, 1);
        chk("R2 act_row", act_row, a);
        chk("R2 no ref", ref_stb, 0);
        step(0, 1, 1, a ^ 12'hFFF);
        chk("R2 act_stb one cycle", act_stb, 0);
        chk("R2 act_row held", act_row, a);
        step(1, 1, 1, 0);
    endtask

    // One plain CBR cycle; w selects good or violating edge
    task automatic t_cbr(input logic w, input int junk);
        step(1, 0, 1, junk);
        step(0, 0, w, junk);
        if (w) begin
            chk("R3 ref_stb", ref_stb, 1);
            chk("R4 ref_row", ref_row, exp_row);
            chk("R6 no viol", viol, 0);
            exp_row = (exp_row + 1) % ROW_MAX;
        end else begin
            chk("R6 viol", viol, 1);
            chk("R6 no ref_stb", ref_stb, 0);
        end
        chk("R7 act_stb low", act_stb, 0);
        chk("R7 act_row kept", act_row, exp_act);
        chk("R8 no hold in plain CBR", dout_hold, 0);
        step(1, 1, 1, 0);
        chk("R3 ref_stb one cycle", ref_stb, 0);
        chk("R6 viol one cycle", viol, 0);
    endtask

    task automatic t_hidden(input int a);
        step(0, 1, 1, a);
        exp_act = a;
        step(0, 0, 1, 0);
        step(1, 0, 1, 0);
        chk("R8 no hold before refresh", dout_hold, 0);
        step(0, 0, 1, 12'h555);
        chk("R8 hidden ref_stb", ref_stb, 1);
        chk("R8 hidden ref_row", ref_row, exp_row);
        chk("R8 hold set", dout_hold, 1);
        exp_row = (exp_row + 1) % ROW_MAX;
        step(0, 0, 1, 0);
        chk("R8 hold kept", dout_hold, 1);
        step(1, 0, 1, 0);
        chk("R8 hold kept after RAS rise", dout_hold, 1);
        step(1, 1, 1, 0);
        chk("R8 hold cleared", dout_hold, 0);
    endtask

    task automatic t_mid_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        exp_act = 0;
        t_cbr(1'b1, 12'h0F0);  // R5: counter continues after reset
    endtask

    task automatic t_long_low;
        int seen = 0;
        step(1, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 1, i);
            seen += ref_stb + act_stb + viol;
        end
        chk("R9 single event over long low", seen, 1);
        exp_row = (exp_row + 1) % ROW_MAX;
        step(1, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_activate(12'hABC);
        t_activate(12'h013);
        t_cbr(1'b1, 12'h777);   // R5 seed row, R3
        t_cbr(1'b1, 12'h888);
        t_cbr(1'b1, 12'h999);
        t_cbr(1'b0, 12'hAAA);   // R6 violation
        t_cbr(1'b1, 12'hBBB);   // row 1023
        t_cbr(1'b1, 12'hCCC);   // R4 wrap to 0
        t_hidden(12'h321);
        t_cbr(1'b1, 12'h111);
        t_mid_reset();
        t_long_low();
        t_cbr(1'b1, 12'h222);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule